// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from a set of numbered sources and decides when and which one the processor core should service. Each source owns an enable bit and a raised flag. A raise pulse always marks the flag, so software can poll it, but the source only joins the pending set when its enable bit is set. A global interrupt-enable bit gates dispatch. Once a request becomes eligible, the controller waits a fixed latency and then services the pending source with the lowest index.

A dispatch asks the core to push its current program counter and supplies the jump target, which is the source index times the vector spacing. The same dispatch clears the global enable and retires the source's flag and pending bit. If the chosen source has been disabled in the meantime, it is dropped from the pending set without a jump. The controller then evaluates the remaining requests afresh. Flags are cleared by writing ones. Source index 0 is reserved and never becomes active.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A raise pulse on source i (i >= 1) sets flags_o[i] on the next clock edge, whatever en_o[i] is.
- R2: A raise marks source i pending only if en_o[i] is 1 in that cycle; a raise on a source that stays pending changes nothing and does not assert wake_o.
- R3: When several sources are pending, the one with the lowest index is serviced first, and vec_o carries that index.
- R4: No dispatch or drop happens in a cycle where gie_o is 0.
- R5: With LATENCY = 2, a dispatch or drop happens in the third consecutive cycle in which gie_o is 1 and some source is pending; any cycle without eligibility restarts the count, and so does each dispatch or drop.
- R6: If the selected source has en_o = 0 in its service cycle, take_o stays 0, its pending bit clears, its flag is kept, and gie_o is unchanged.
- R7: In a dispatch cycle take_o and push_o are 1, push_pc_o equals pc_i, and jump_o equals vec_o times VEC_SIZE; after that edge gie_o is 0 and the serviced flag and pending bit are 0.
- R8: A write with clr_we_i set clears flags and pending bits where clr_wdata_i has a 1 and leaves bits with a 0 unchanged; a raise on the same source in the same cycle sets the flag again, and sets the pending bit again if en_o is 1.
- R9: wake_o is 1 in exactly the cycles in which some source becomes newly pending.
- R10: Source 0 can never be raised, enabled or pending; bit 0 of flags_o, pend_o and en_o is always 0.
- R11: gie_clr_i clears gie_o and takes precedence over gie_set_i; gie_set_i alone sets it; en_we_i loads en_o from en_wdata_i.
- R12: After reset, flags_o, pend_o, en_o and gie_o are all 0 and take_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_i | input | N_SRC | Per-source raise pulses |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | N_SRC | New enable bits |
| clr_we_i | input | 1 | Write strobe for write-one-to-clear of flags |
| clr_wdata_i | input | N_SRC | Ones select the flags to clear |
| gie_set_i | input | 1 | Set the global interrupt enable |
| gie_clr_i | input | 1 | Clear the global interrupt enable |
| pc_i | input | PC_W | Current program counter of the core |
| flags_o | output | N_SRC | Raised flags |
| pend_o | output | N_SRC | Pending set |
| en_o | output | N_SRC | Enable bits |
| gie_o | output | 1 | Global interrupt enable |
| wake_o | output | 1 | A source became pending this cycle |
| take_o | output | 1 | Dispatch in this cycle |
| vec_o | output | $clog2(N_SRC) | Serviced source index |
| jump_o | output | PC_W | Jump target for the dispatch |
| push_o | output | 1 | Request to push the program counter |
| push_pc_o | output | PC_W | Program counter to push |

## Verification
Directed sequences try the controller with a single request, with two requests pending at once, and with requests raised while the global enable is off. These separate the priority order from the arrival order and show that the gate holds. Further sequences disable a source after it became pending, raise a source that is already pending, collide a clear with a raise, and target source 0. These tell a drop apart from a jump, and a new request apart from a duplicate. A long random mix of all inputs is then compared cycle by cycle against a behavioural model, which exposes latency counting errors such as off-by-one waits or a count that is not restarted.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic [1:0] {
        SVC_IDLE = 2'd0,
        SVC_TAKE = 2'd1,
        SVC_DROP = 2'd2
    } svc_e;

    function automatic logic [31:0] vec_to_addr(input logic [31:0] idx,
                                                input logic [31:0] spacing);
        return idx * spacing;
    endfunction

endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] raise_i,
    input  logic             en_we_i,
    input  logic [N_SRC-1:0] en_wdata_i,
    input  logic             clr_we_i,
    input  logic [N_SRC-1:0] clr_wdata_i,
    input  logic [N_SRC-1:0] take_mask_i,
    input  logic [N_SRC-1:0] drop_mask_i,
    output logic [N_SRC-1:0] flags_o,
    output logic [N_SRC-1:0] pend_o,
    output logic [N_SRC-1:0] en_o,
    output logic             wake_o
);
    localparam logic [N_SRC-1:0] SRC_OK = ~N_SRC'(1);

    logic [N_SRC-1:0] flags_q, pend_q, en_q;
    logic [N_SRC-1:0] raise_v, clr_m, pend_kept, new_pend;

    always_comb begin
        raise_v   = raise_i & SRC_OK;
        clr_m     = clr_we_i ? clr_wdata_i : '0;
        pend_kept = pend_q & ~clr_m & ~take_mask_i & ~drop_mask_i;
        new_pend  = raise_v & en_q & ~pend_kept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            pend_q  <= '0;
            en_q    <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_m & ~take_mask_i) | raise_v;
            pend_q  <= pend_kept | new_pend;
            if (en_we_i)
                en_q <= en_wdata_i & SRC_OK;
        end
    end

    assign flags_o = flags_q;
    assign pend_o  = pend_q;
    assign en_o    = en_q;
    assign wake_o  = |new_pend;

    assert_src0_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !flags_q[0] && !pend_q[0] && !en_q[0]);

    assert_wake_sets_pend_R9: assert property (@(posedge clk) disable iff (rst)
        wake_o |=> |pend_q);

endmodule

// File: rtl/vic_pick.sv
module vic_pick #(
    parameter int N_SRC = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] pend_i,
    output logic [IDX_W-1:0] sel_o,
    output logic             any_o
);
    always_comb begin
        sel_o = '0;
        for (int i = N_SRC - 1; i >= 1; i--) begin
            if (pend_i[i])
                sel_o = IDX_W'(i);
        end
        any_o = |pend_i;
    end
endmodule

// File: rtl/vic_seq.sv
module vic_seq
    import vic_pkg::*;
#(
    parameter int LATENCY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic gie_set_i,
    input  logic gie_clr_i,
    input  logic any_pend_i,
    input  logic sel_en_i,
    output logic gie_o,
    output svc_e svc_o
);
    localparam int LAT_W = (LATENCY > 0) ? $clog2(LATENCY + 1) : 1;
    localparam logic [LAT_W-1:0] LAT_LOAD = LAT_W'(LATENCY);

    logic [LAT_W-1:0] lat_q;
    logic gie_q, elig, fire;

    assign elig = gie_q && any_pend_i;
    assign fire = elig && (lat_q == '0);

    always_comb begin
        if (!fire)         svc_o = SVC_IDLE;
        else if (sel_en_i) svc_o = SVC_TAKE;
        else               svc_o = SVC_DROP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= LAT_LOAD;
            gie_q <= 1'b0;
        end else begin
            if (!elig || fire)
                lat_q <= LAT_LOAD;
            else
                lat_q <= lat_q - 1'b1;
            if (svc_o == SVC_TAKE || gie_clr_i)
                gie_q <= 1'b0;
            else if (gie_set_i)
                gie_q <= 1'b1;
        end
    end

    assign gie_o = gie_q;

    assert_gated_R4: assert property (@(posedge clk) disable iff (rst)
        (svc_o != SVC_IDLE) |-> gie_q);

    assert_take_clears_gie_R7: assert property (@(posedge clk) disable iff (rst)
        (svc_o == SVC_TAKE) |=> !gie_q);

    generate
        if (LATENCY >= 2) begin : g_lat_chk
            assert_wait_R5: assert property (@(posedge clk) disable iff (rst)
                (svc_o != SVC_IDLE) |-> ($past(elig) && $past(elig, 2)));
        end
    endgenerate

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int N_SRC    = 8,
    parameter int VEC_SIZE = 4,
    parameter int PC_W     = 16,
    parameter int LATENCY  = 2,
    localparam int IDX_W   = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] raise_i,
    input  logic             en_we_i,
    input  logic [N_SRC-1:0] en_wdata_i,
    input  logic             clr_we_i,
    input  logic [N_SRC-1:0] clr_wdata_i,
    input  logic             gie_set_i,
    input  logic             gie_clr_i,
    input  logic [PC_W-1:0]  pc_i,
    output logic [N_SRC-1:0] flags_o,
    output logic [N_SRC-1:0] pend_o,
    output logic [N_SRC-1:0] en_o,
    output logic             gie_o,
    output logic             wake_o,
    output logic             take_o,
    output logic [IDX_W-1:0] vec_o,
    output logic [PC_W-1:0]  jump_o,
    output logic             push_o,
    output logic [PC_W-1:0]  push_pc_o
);
    logic [N_SRC-1:0] take_mask, drop_mask, sel_bit;
    logic [IDX_W-1:0] sel;
    logic             any_pend;
    svc_e             svc;

    vic_src_bank #(.N_SRC(N_SRC)) u_bank (
        .clk(clk), .rst(rst), .raise_i(raise_i),
        .en_we_i(en_we_i), .en_wdata_i(en_wdata_i),
        .clr_we_i(clr_we_i), .clr_wdata_i(clr_wdata_i),
        .take_mask_i(take_mask), .drop_mask_i(drop_mask),
        .flags_o(flags_o), .pend_o(pend_o), .en_o(en_o), .wake_o(wake_o)
    );

    vic_pick #(.N_SRC(N_SRC)) u_pick (
        .pend_i(pend_o), .sel_o(sel), .any_o(any_pend)
    );

    vic_seq #(.LATENCY(LATENCY)) u_seq (
        .clk(clk), .rst(rst), .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i),
        .any_pend_i(any_pend), .sel_en_i(en_o[sel]),
        .gie_o(gie_o), .svc_o(svc)
    );

    always_comb begin
        sel_bit   = N_SRC'(1) << sel;
        take_mask = (svc == SVC_TAKE) ? sel_bit : '0;
        drop_mask = (svc == SVC_DROP) ? sel_bit : '0;
    end

    assign take_o    = (svc == SVC_TAKE);
    assign vec_o     = sel;
    assign jump_o    = PC_W'(vec_to_addr(32'(sel), 32'(VEC_SIZE)));
    assign push_o    = take_o;
    assign push_pc_o = pc_i;

    assert_lowest_first_R3: assert property (@(posedge clk) disable iff (rst)
        take_o |-> ((pend_o & ((N_SRC'(1) << vec_o) - N_SRC'(1))) == '0));

    assert_taken_is_live_R6: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (pend_o[vec_o] && en_o[vec_o]));

endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
    localparam int N   = 8;
    localparam int VS  = 4;
    localparam int PW  = 16;
    localparam int LAT = 2;
    localparam int IW  = $clog2(N);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] raise_i = '0, en_wdata_i = '0, clr_wdata_i = '0;
    logic en_we_i = 1'b0, clr_we_i = 1'b0, gie_set_i = 1'b0, gie_clr_i = 1'b0;
    logic [PW-1:0] pc_i = '0;
    logic [N-1:0] flags_o, pend_o, en_o;
    logic gie_o, wake_o, take_o, push_o;
    logic [IW-1:0] vec_o;
    logic [PW-1:0] jump_o, push_pc_o;

    always #5 clk = ~clk;

    vec_irq_ctrl #(.N_SRC(N), .VEC_SIZE(VS), .PC_W(PW), .LATENCY(LAT)) dut (
        .clk(clk), .rst(rst), .raise_i(raise_i), .en_we_i(en_we_i),
        .en_wdata_i(en_wdata_i), .clr_we_i(clr_we_i), .clr_wdata_i(clr_wdata_i),
        .gie_set_i(gie_set_i), .gie_clr_i(gie_clr_i), .pc_i(pc_i),
        .flags_o(flags_o), .pend_o(pend_o), .en_o(en_o), .gie_o(gie_o),
        .wake_o(wake_o), .take_o(take_o), .vec_o(vec_o), .jump_o(jump_o),
        .push_o(push_o), .push_pc_o(push_pc_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    // behavioural reference state
    logic [N-1:0] m_flag = '0, m_pend = '0, m_en = '0;
    logic m_gie = 1'b0;
    int   m_wait = LAT;

    // last observed dispatch
    logic saw_take = 1'b0;
    int   saw_vec = 0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic ew, input logic [N-1:0] ed,
                        input logic cw, input logic [N-1:0] cd,
                        input logic gs, input logic gc);
        logic elig, fire, tk, dr;
        int sel;
        logic [N-1:0] svc_bit, clr_m, kept, newp, rv;
        raise_i = r; en_we_i = ew; en_wdata_i = ed; clr_we_i = cw; clr_wdata_i = cd;
        gie_set_i = gs; gie_clr_i = gc; pc_i = PW'($urandom);
        #1;
        elig = m_gie && (m_pend != '0);
        fire = elig && (m_wait == 0);
        sel = 0;
        for (int i = 1; i < N; i++) if (m_pend[i] && sel == 0) sel = i;
        tk = fire && m_en[sel];
        dr = fire && !m_en[sel];
        svc_bit = '0;
        if (fire) svc_bit[sel] = 1'b1;
        rv = r; rv[0] = 1'b0;
        clr_m = cw ? cd : '0;
        kept = m_pend & ~clr_m & ~svc_bit;
        newp = rv & m_en & ~kept;
        saw_take = take_o;
        saw_vec = int'(vec_o);
        check(32'(take_o), 32'(tk), "R5 take timing");
        check(32'(push_o), 32'(tk), "R7 push request");
        check(32'(wake_o), 32'(newp != '0), "R9 wake");
        if (tk) begin
            check(32'(vec_o), 32'(sel), "R3 vector choice");
            check(32'(jump_o), 32'(sel * VS), "R7 jump target");
            check(32'(push_pc_o), 32'(pc_i), "R7 pushed pc");
        end
        @(posedge clk);
        m_flag = (m_flag & ~clr_m & ~(tk ? svc_bit : '0)) | rv;
        m_pend = kept | newp;
        if (ew) begin m_en = ed; m_en[0] = 1'b0; end
        if (!elig || fire) m_wait = LAT; else m_wait--;
        if (tk || gc) m_gie = 1'b0; else if (gs) m_gie = 1'b1;
        @(negedge clk);
        check(32'(flags_o), 32'(m_flag), "R1 flags");
        check(32'(pend_o), 32'(m_pend), "R2 pending");
        check(32'(en_o), 32'(m_en), "R11 enables");
        check(32'(gie_o), 32'(m_gie), "R11 global enable");
    endtask

    task automatic idle();
        step('0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        check(32'(flags_o), 0, "R12 flags");
        check(32'(pend_o), 0, "R12 pending");
        check(32'(en_o), 0, "R12 enables");
        check(32'(gie_o), 0, "R12 gie");
        check(32'(take_o), 0, "R12 take");

        // R1 raise a disabled source: flag only
        step(8'h08, 0, '0, 0, '0, 0, 0);
        check(32'(flags_o[3]), 1, "R1 flag on disabled source");
        check(32'(pend_o[3]), 0, "R2 disabled source not pending");
        step('0, 0, '0, 1, 8'h08, 0, 0);

        // R4 enable 1,3,5 and raise with gie off: nothing dispatched
        step('0, 1, 8'h2A, 0, '0, 0, 0);
        step(8'h28, 0, '0, 0, '0, 0, 0);
        check(32'(pend_o), 32'h28, "R2 two pending");
        for (int k = 0; k < 5; k++) begin
            idle();
            check(32'(saw_take), 0, "R4 no dispatch with gie clear");
        end
        // R2 repeat raise on a pending source
        step(8'h08, 0, '0, 0, '0, 0, 0);

        // R5 / R3 set gie, dispatch on third eligible cycle
        step('0, 0, '0, 0, '0, 1, 0);
        cyc = 0;
        for (int k = 0; k < 6 && !saw_take; k++) begin idle(); cyc++; end
        check(32'(cyc), 3, "R5 latency count");
        check(32'(saw_vec), 3, "R3 lowest index first");
        check(32'(gie_o), 0, "R7 gie cleared");
        check(32'(flags_o[3]), 0, "R7 flag retired");
        step('0, 0, '0, 0, '0, 1, 0);
        for (int k = 0; k < 4; k++) idle();

        // R6 disabled before dispatch is dropped
        step('0, 1, 8'h40, 0, '0, 0, 0);
        step(8'h40, 0, '0, 0, '0, 0, 0);
        step('0, 1, 8'h00, 0, '0, 1, 0);
        for (int k = 0; k < 4; k++) begin
            idle();
            check(32'(saw_take), 0, "R6 masked source not taken");
        end
        check(32'(pend_o[6]), 0, "R6 pending dropped");
        check(32'(flags_o[6]), 1, "R6 flag kept");
        check(32'(gie_o), 1, "R6 gie unchanged");

        // R8 write-one-to-clear, and clear colliding with raise
        step('0, 0, '0, 0, '0, 0, 1);
        step('0, 1, 8'h06, 0, '0, 0, 0);
        step(8'h06, 0, '0, 0, '0, 0, 0);
        step('0, 0, '0, 1, 8'h04, 0, 0);
        check(32'(flags_o & 8'h06), 32'h02, "R8 only ones clear");
        step(8'h02, 0, '0, 1, 8'h02, 0, 0);
        check(32'(pend_o[1]), 1, "R8 raise wins over clear");

        // R10 source 0
        step(8'h01, 1, 8'hFF, 0, '0, 0, 0);
        check(32'(flags_o[0] | pend_o[0] | en_o[0]), 0, "R10 source 0 inert");

        // R11 set and clear together
        step('0, 0, '0, 0, '0, 1, 1);
        check(32'(gie_o), 0, "R11 clear wins");

        // mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] r;
            r = (($urandom % 4) == 0) ? N'($urandom) & N'($urandom) : '0;
            step(r, ($urandom % 16) == 0, N'($urandom),
                 ($urandom % 10) == 0, N'($urandom) & N'($urandom),
                 ($urandom % 6) == 0, ($urandom % 40) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule